// File: doc/BRIEF.md
# Paged DRAM Controller with Background Refresh

This block sits between a host that issues single-bit reads and writes and a 64K x 1 dynamic memory whose address pins are shared between row and column. Each host request carries a 16-bit address. The upper byte selects the row and goes out with the row strobe. The lower byte selects the column and goes out with the column strobe. The controller counts out the row-open, column and write-back phases in clock cycles, and each phase length is set by a parameter.

After an access the row is left open. A later request to the same row therefore needs only another column strobe. A request to a different row closes the page first. A refresh scheduler runs alongside host traffic. It raises one refresh request per refresh interval and walks the row index upward, so that every row is opened and written back once per period. A waiting refresh wins over host requests, and it closes any open page before it runs.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, the row strobe, column strobe, write enable and read-valid outputs are all 0.
- R2: A request to a closed row holds the row strobe high with the memory address equal to request address bits [15:8] for exactly T_ROW cycles. After that, the column strobe is high for T_COL cycles with the memory address equal to bits [7:0].
- R3: A request to the row that is already open raises only the column strobe. The row strobe stays high between the two accesses, so a burst to one row opens that row once.
- R4: Whenever the row strobe falls, it stays low for at least T_PRE cycles before it rises again. This is the write-back time.
- R5: A read returns the bit most recently written to that address on rd_data_o. It is qualified by rd_valid_o, which is high for a single cycle, and reads complete in request order.
- R6: A refresh holds the row strobe high for exactly T_ROW cycles with no column strobe and then closes the row.
- R7: Refresh rows follow 0, 1, 2 and so on up to 255, then wrap to 0. The first refresh after reset uses row 0.
- R8: A refresh runs within a bounded number of cycles of its due time even under back-to-back page hits. The gap between consecutive refreshes is REF_INTERVAL ±16 cycles.
- R9: req_ready_o is 0 whenever the column strobe is high and while a row is opening or a refresh is under way.
- R10: A write raises mem_we_o only together with the column strobe and drives the request's data bit on mem_din_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid is also high |
| req_addr_i | input | 16 | Bit address, row in [15:8], column in [7:0] |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 1 | Write data bit |
| rd_valid_o | output | 1 | One-cycle pulse marking read data |
| rd_data_o | output | 1 | Read data bit |
| mem_row_stb_o | output | 1 | Row strobe, active high |
| mem_col_stb_o | output | 1 | Column strobe, active high |
| mem_we_o | output | 1 | Memory write select |
| mem_addr_o | output | 8 | Multiplexed row/column address |
| mem_din_o | output | 1 | Data into memory |
| mem_dout_i | input | 1 | Data out of memory |

## Verification
The bench targets bursts to one row that begin right after a refresh. A controller that cycles the row for each bit would show more than one row opening there. It alternates rows to force closes, and a controller that re-raised the strobe too early would cut the write-back short. It keeps random mixed traffic running long enough for the refresh row counter to wrap past 255. A skipped, repeated or late refresh row shows up as an out-of-order row number or an out-of-bound gap. A scoreboard of expected read bits catches data taken from the wrong row or column, as well as lost or duplicated read pulses.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_OPEN,
        ST_PRE,
        ST_REF
    } dpc_state_e;
endpackage

// File: rtl/dpc_refresh.sv
// Refresh scheduler: interval timer plus round-robin row index.
module dpc_refresh #(
    parameter int INTERVAL = 390,
    parameter int ROW_W    = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ack_i,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [TW-1:0]    tmr;
        logic             pend;
        logic [ROW_W-1:0] row;
    } ref_t;

    ref_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ack_i) begin
            r_d.pend = 1'b0;
            r_d.row  = r_q.row + 1'b1;
        end
        if (r_q.tmr == '0) begin
            r_d.tmr  = TW'(INTERVAL - 1);
            r_d.pend = 1'b1;
        end else begin
            r_d.tmr = r_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.tmr  <= TW'(INTERVAL - 1);
            r_q.pend <= 1'b0;
            r_q.row  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend_o = r_q.pend;
    assign row_o  = r_q.row;
endmodule

// File: rtl/dpc_page.sv
// Open-page tracker: remembers which row is held open and flags hits.
module dpc_page #(
    parameter int ROW_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic [ROW_W-1:0] cmp_row_i,
    output logic             hit_o
);
    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
    } page_t;

    page_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (close_i) begin
            p_d.vld = 1'b0;
        end else if (open_i) begin
            p_d.vld = 1'b1;
            p_d.row = open_row_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign hit_o = p_q.vld && (p_q.row == cmp_row_i);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int T_ROW        = 5,
    parameter int T_COL        = 1,
    parameter int T_PRE        = 3,
    parameter int REF_INTERVAL = 390
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic                req_we_i,
    input  logic                req_wdata_i,
    output logic                rd_valid_o,
    output logic                rd_data_o,
    output logic                mem_row_stb_o,
    output logic                mem_col_stb_o,
    output logic                mem_we_o,
    output logic [ADDR_W/2-1:0] mem_addr_o,
    output logic                mem_din_o,
    input  logic                mem_dout_i
);
    localparam int ROW_W = ADDR_W / 2;
    localparam int T_MAX = (T_ROW > T_PRE) ? ((T_ROW > T_COL) ? T_ROW : T_COL)
                                           : ((T_PRE > T_COL) ? T_PRE : T_COL);
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        dpc_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic              wdata;
        logic              rvalid;
        logic              rdata;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic             ref_pend, ref_ack, page_hit, page_open, page_close, accept;
    logic [ROW_W-1:0] ref_row, req_row;

    assign req_row = req_addr_i[ADDR_W-1:ROW_W];

    dpc_refresh #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_refresh (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ack_i  (ref_ack),
        .pend_o (ref_pend),
        .row_o  (ref_row)
    );

    dpc_page #(.ROW_W(ROW_W)) u_page (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .open_i     (page_open),
        .close_i    (page_close),
        .open_row_i (req_row),
        .cmp_row_i  (req_row),
        .hit_o      (page_hit)
    );

    assign req_ready_o = !ref_pend &&
                         ((c_q.st == ST_IDLE) || ((c_q.st == ST_OPEN) && page_hit));
    assign accept = req_valid_i && req_ready_o;

    always_comb begin
        c_d        = c_q;
        c_d.rvalid = 1'b0;
        ref_ack    = 1'b0;
        page_open  = 1'b0;
        page_close = 1'b0;
        if (accept) begin
            c_d.addr  = req_addr_i;
            c_d.we    = req_we_i;
            c_d.wdata = req_wdata_i;
        end
        unique case (c_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    c_d.st  = ST_REF;
                    c_d.cnt = CNT_W'(T_ROW - 1);
                end else if (accept) begin
                    c_d.st    = ST_ROW;
                    c_d.cnt   = CNT_W'(T_ROW - 1);
                    page_open = 1'b1;
                end
            end
            ST_ROW: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st  = ST_COL;
                    c_d.cnt = CNT_W'(T_COL - 1);
                end
            end
            ST_COL: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st = ST_OPEN;
                    if (!c_q.we) begin
                        c_d.rvalid = 1'b1;
                        c_d.rdata  = mem_dout_i;
                    end
                end
            end
            ST_OPEN: begin
                if (ref_pend || (req_valid_i && !page_hit)) begin
                    c_d.st     = ST_PRE;
                    c_d.cnt    = CNT_W'(T_PRE - 1);
                    page_close = 1'b1;
                end else if (accept) begin
                    c_d.st  = ST_COL;
                    c_d.cnt = CNT_W'(T_COL - 1);
                end
            end
            ST_PRE: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st = ST_IDLE;
                end
            end
            ST_REF: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st  = ST_PRE;
                    c_d.cnt = CNT_W'(T_PRE - 1);
                    ref_ack = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        mem_row_stb_o = (c_q.st == ST_ROW) || (c_q.st == ST_COL) ||
                        (c_q.st == ST_OPEN) || (c_q.st == ST_REF);
        mem_col_stb_o = (c_q.st == ST_COL);
        mem_we_o      = (c_q.st == ST_COL) && c_q.we;
        mem_din_o     = c_q.wdata;
        if (c_q.st == ST_REF) begin
            mem_addr_o = ref_row;
        end else if (c_q.st == ST_COL) begin
            mem_addr_o = c_q.addr[ROW_W-1:0];
        end else begin
            mem_addr_o = c_q.addr[ADDR_W-1:ROW_W];
        end
    end

    assign rd_valid_o = c_q.rvalid;
    assign rd_data_o  = c_q.rdata;
endmodule

// File: rtl/dpc_checks.sv
module dpc_checks #(
    parameter int T_PRE = 3,
    parameter int MA_W  = 8
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            req_ready_o,
    input logic            rd_valid_o,
    input logic            mem_row_stb_o,
    input logic            mem_col_stb_o,
    input logic            mem_we_o,
    input logic [MA_W-1:0] mem_addr_o
);
    logic [7:0] low_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            low_cnt <= 8'hff;
        end else if (mem_row_stb_o) begin
            low_cnt <= '0;
        end else if (low_cnt != 8'hff) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk_i)
        rst_i |=> (!mem_row_stb_o && !mem_col_stb_o && !mem_we_o && !rd_valid_o));

    a_r2_col_inside_row: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_col_stb_o |-> mem_row_stb_o);

    a_r2_row_addr_steady: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_row_stb_o && $past(mem_row_stb_o) && !mem_col_stb_o && !$past(mem_col_stb_o))
        |-> $stable(mem_addr_o));

    a_r4_writeback_time: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(mem_row_stb_o) |-> (low_cnt >= 8'(T_PRE)));

    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_o |=> !rd_valid_o);

    a_r9_no_ready_in_col: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_col_stb_o |-> !req_ready_o);

    a_r10_we_with_col: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we_o |-> mem_col_stb_o);
endmodule

bind dram_page_ctrl dpc_checks #(.T_PRE(T_PRE), .MA_W(ADDR_W/2)) u_dpc_checks (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .req_ready_o   (req_ready_o),
    .rd_valid_o    (rd_valid_o),
    .mem_row_stb_o (mem_row_stb_o),
    .mem_col_stb_o (mem_col_stb_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o)
);

// File: tb/test_dram_page_ctrl.sv
`timescale 1ns/1ps
module test_dram_page_ctrl;
    localparam int TR = 5, TC = 1, TP = 3, RI = 64;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
    logic [15:0] req_addr = '0;
    logic req_ready, rd_valid, rd_data, row_stb, col_stb, mem_we, mem_din;
    logic [7:0] mem_addr;
    logic mem_dout = 1'b0;

    always #5 clk = ~clk;

    dram_page_ctrl #(.T_ROW(TR), .T_COL(TC), .T_PRE(TP), .REF_INTERVAL(RI)) i_dram_page_ctrl (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
        .req_we_i(req_we), .req_wdata_i(req_wdata),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .mem_row_stb_o(row_stb), .mem_col_stb_o(col_stb), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_din_o(mem_din), .mem_dout_i(mem_dout)
    );

    int n_chk = 0, n_fail = 0;
    bit shadow[int];
    bit cells[int];
    bit exp_q[$];
    bit mon_on = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory model: latches row on strobe rise, acts on column strobe.
    logic [7:0] m_row;
    logic m_prev_row = 1'b0;
    always @(negedge clk) begin
        if (row_stb && !m_prev_row) m_row = mem_addr;
        if (col_stb) begin
            if (mem_we) cells[{m_row, mem_addr}] = mem_din;
            else mem_dout = cells.exists({m_row, mem_addr}) ? cells[{m_row, mem_addr}] : 1'b0;
        end
        m_prev_row = row_stb;
    end

    // Monitor: strobe timing, refresh order, scoreboard.
    int cyc = 0, hi_cnt = 0, low_cnt = 1000, ref_count = 0, host_opens = 0;
    int last_ref = 0, exp_ref_row = 0;
    bit p_row = 1'b0, p_col = 1'b0, saw_col = 1'b0;
    logic [7:0] rise_addr;
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (row_stb && !p_row) begin
                check(low_cnt >= TP, "R4 write-back low time", low_cnt, TP);
                check(!req_ready, "R9 ready low on row open", req_ready, 0);
                hi_cnt = 1; saw_col = 1'b0; rise_addr = mem_addr;
            end else if (row_stb && !col_stb && !saw_col) begin
                hi_cnt++;
            end
            if (col_stb && !p_col && !saw_col) begin
                check(hi_cnt == TR, "R2 row phase length", hi_cnt, TR);
                saw_col = 1'b1;
                host_opens++;
            end
            if (!row_stb && p_row) begin
                low_cnt = 1;
                if (!saw_col) begin
                    check(hi_cnt == TR, "R6 refresh row phase", hi_cnt, TR);
                    check(rise_addr == 8'(exp_ref_row), "R7 refresh row order", rise_addr, exp_ref_row);
                    if (ref_count > 0)
                        check((cyc - last_ref >= RI - 16) && (cyc - last_ref <= RI + 16),
                              "R8 refresh gap", cyc - last_ref, RI);
                    exp_ref_row = (exp_ref_row + 1) % 256;
                    ref_count++;
                    last_ref = cyc;
                end
            end else if (!row_stb) begin
                low_cnt++;
            end
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected read pulse", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R5 read data", rd_data, e);
                end
            end
        end
        p_row = row_stb; p_col = col_stb;
    end

    // Driver: one request; expected read data goes to the queue.
    task automatic issue(input logic [15:0] a, input bit we, input bit d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        if (we) shadow[a] = d;
        else exp_q.push_back(shadow.exists(a) ? shadow[a] : 1'b0);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_refresh();
        int r0;
        r0 = ref_count;
        while (ref_count == r0) @(negedge clk);
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 200) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(!row_stb && !col_stb && !mem_we && !rd_valid, "R1 outputs during reset",
              {row_stb, col_stb, mem_we, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!row_stb && !col_stb && !mem_we && !rd_valid, "R1 outputs after reset",
              {row_stb, col_stb, mem_we, rd_valid}, 0);
        mon_on = 1'b1;

        // R10 / R5: writes then reads across rows
        issue(16'h1234, 1'b1, 1'b1);
        issue(16'hAB01, 1'b1, 1'b1);
        issue(16'h1235, 1'b1, 1'b0);
        issue(16'h1234, 1'b0, 1'b0);
        issue(16'hAB01, 1'b0, 1'b0);
        issue(16'h1235, 1'b0, 1'b0);
        issue(16'h7777, 1'b0, 1'b0);
        drain();

        // R3: burst to one row just after a refresh opens that row once
        wait_refresh();
        begin
            int o0;
            o0 = host_opens;
            for (int i = 0; i < 4; i++) issue({8'h3C, 8'(i * 5)}, 1'b1, i[0]);
            for (int i = 0; i < 4; i++) issue({8'h3C, 8'(i * 5)}, 1'b0, 1'b0);
            drain();
            check(host_opens - o0 == 1, "R3 single row open for page burst", host_opens - o0, 1);
        end

        // R4: alternating rows force close and reopen
        for (int i = 0; i < 6; i++) issue({8'(i[0] ? 8'h55 : 8'hAA), 8'(i)}, 1'b1, ~i[0]);
        for (int i = 0; i < 6; i++) issue({8'(i[0] ? 8'h55 : 8'hAA), 8'(i)}, 1'b0, 1'b0);
        drain();

        // Long mixed traffic so the refresh row counter wraps (R7, R8)
        for (int i = 0; i < 1800; i++) begin
            logic [15:0] a;
            a = {6'd0, 2'($urandom), 5'd0, 3'($urandom)};
            issue(a, 1'($urandom), 1'($urandom));
        end
        drain();
        while (ref_count < 270) @(negedge clk);
        check(ref_count > 256, "R7 refresh counter wrapped", ref_count, 257);
        check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule